// File: doc/BRIEF.md
# Configurable-Priority Three-Source Cell Multiplexer

This block sits in front of a cell bus transmit queue. It merges whole cells from three upstream queues into one output stream: a data queue, a control queue and a loopback queue. Each upstream queue raises a level flag once it holds at least one complete cell, then offers that cell word by word on a valid/ready stream with start-of-cell and end-of-cell markers. The block picks one source at a cell boundary, forwards all of that cell's words, and only then picks again.

A plain configuration pin chooses whether data or control cells win when both are waiting. Loopback cells are always taken last. The pin is sampled only at cell boundaries, so changing it never disturbs a cell already in flight.

Back-pressure rules: an input word moves only on a cycle where the output is ready and the selected source is valid. The output valid follows the selected source's valid, and the output ready is passed straight back to the selected source only. A word offered while the output is not ready stays where it is, and no input word is consumed. After each cell there is one idle cycle, which is the selection slot.

Top module: `cell_prio_mux`

## Requirements
- R1: With the priority register at 0, a selection picks the data source (index 0) if it has a cell available, ahead of control and loopback.
- R2: With the priority register at 1, a selection picks the control source (index 1) if it has a cell available, ahead of data and loopback.
- R3: The loopback source (index 2) is selected only when neither data nor control has a cell available at the selection cycle.
- R4: Reset clears the priority register to 0. The first selection after reset is therefore data-first, even if the configuration pin is held at 1.
- R5: Once a cell starts, only words of that source are forwarded until the cell ends. A source that becomes available mid-cell waits for the next boundary.
- R6: A cell is 14 words of 32 bits. The cell ends on the 14th accepted word (index 13), which carries the end-of-cell marker, and the first word carries the start-of-cell marker.
- R7: While out_ready is low, every in_ready bit is low and no input word is consumed. out_valid is high only when the selected source is valid.
- R8: The configuration pin is loaded into the priority register only while idle or on the last word of a cell. A change made mid-cell governs the next selection, not the current cell.
- R9: out_src reports the source of the cell in flight: 0 data, 1 control, 2 loopback, 3 none (idle, out_valid low).
- R10: During and right after reset, out_valid and all in_ready bits are low and out_src is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ctrl_first | input | 1 | 1: control beats data; 0: data beats control |
| in_avail | input | 3 | Per source: a complete cell is queued |
| in_valid | input | 3 | Per source: word valid |
| in_ready | output | 3 | Per source: word accepted |
| in_data | input | 3x32 | Per source word (packed, index = source) |
| in_sop | input | 3 | Per source start-of-cell marker |
| in_eop | input | 3 | Per source end-of-cell marker |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream can accept |
| out_data | output | 32 | Output word |
| out_sop | output | 1 | Output start-of-cell |
| out_eop | output | 1 | Output end-of-cell |
| out_src | output | 2 | Source of the cell in flight (3 = idle) |

## Verification
The bench queues a second control cell and flips the configuration pin while the first control cell is in flight. A design that latched the pin only when idle would send the stale control cell ahead of data. It holds the pin at 1 through reset with all three sources loaded, so a design that took the pin rather than the reset value would start with control. It toggles out_ready and the data source's valid together, which exposes a ready that leaks through a stall as a skipped word index. It also offers higher-priority cells in the middle of a running cell, so a design that re-arbitrated per word would interleave words of two sources.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  localparam int NSRC = 3;

  typedef enum logic [1:0] {
    SRC_DATA = 2'd0,
    SRC_CTRL = 2'd1,
    SRC_LOOP = 2'd2,
    SRC_NONE = 2'd3
  } src_e;
endpackage

// File: rtl/cpm_pick.sv
module cpm_pick
  import cpm_pkg::*;
(
  input  logic [NSRC-1:0] avail,
  input  logic            ctrl_first,
  output logic            any,
  output src_e            win
);
  src_e first_s, second_s;

  always_comb begin
    first_s  = ctrl_first ? SRC_CTRL : SRC_DATA;
    second_s = ctrl_first ? SRC_DATA : SRC_CTRL;
    any      = |avail;
    if (avail[int'(first_s)])       win = first_s;
    else if (avail[int'(second_s)]) win = second_s;
    else if (avail[int'(SRC_LOOP)]) win = SRC_LOOP;
    else                            win = SRC_NONE;
  end
endmodule

// File: rtl/cpm_beat_ctr.sv
module cpm_beat_ctr #(
  parameter int WORDS = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic eop,
  output logic at_last
);
  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [IW-1:0] LAST = IW'(WORDS - 1);

  logic [IW-1:0] idx;

  assign at_last = (idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx <= '0;
    else if (beat) begin
      if (at_last)    idx <= '0;
      else            idx <= idx + 1'b1;
    end
  end

  // R6
  eop_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> (eop == (idx == LAST)));
endmodule

// File: rtl/cpm_route.sv
module cpm_route
  import cpm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     active,
  input  src_e                     sel,
  input  logic [NSRC-1:0]          in_valid,
  input  logic [NSRC-1:0][W-1:0]   in_data,
  input  logic [NSRC-1:0]          in_sop,
  input  logic [NSRC-1:0]          in_eop,
  output logic [NSRC-1:0]          in_ready,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic [W-1:0]             out_data,
  output logic                     out_sop,
  output logic                     out_eop
);
  for (genvar k = 0; k < NSRC; k++) begin : g_rdy
    assign in_ready[k] = active && (sel == src_e'(k)) && out_ready;
  end

  always_comb begin
    out_valid = 1'b0;
    out_data  = '0;
    out_sop   = 1'b0;
    out_eop   = 1'b0;
    if (active && sel != SRC_NONE) begin
      out_valid = in_valid[int'(sel)];
      out_data  = in_data[int'(sel)];
      out_sop   = in_sop[int'(sel)];
      out_eop   = in_eop[int'(sel)];
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> (in_ready == '0));
  // R7
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));
endmodule

// File: rtl/cell_prio_mux.sv
module cell_prio_mux
  import cpm_pkg::*;
#(
  parameter int W     = 32,
  parameter int WORDS = 14
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_ctrl_first,
  input  logic [NSRC-1:0]        in_avail,
  input  logic [NSRC-1:0]        in_valid,
  output logic [NSRC-1:0]        in_ready,
  input  logic [NSRC-1:0][W-1:0] in_data,
  input  logic [NSRC-1:0]        in_sop,
  input  logic [NSRC-1:0]        in_eop,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [W-1:0]           out_data,
  output logic                   out_sop,
  output logic                   out_eop,
  output logic [1:0]             out_src
);
  logic active, prio_q, any, beat, at_last, cell_end;
  src_e sel, win;

  cpm_pick u_pick (
    .avail      (in_avail),
    .ctrl_first (prio_q),
    .any        (any),
    .win        (win)
  );

  cpm_route #(.W(W)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .sel       (sel),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop)
  );

  assign beat = out_valid && out_ready;

  cpm_beat_ctr #(.WORDS(WORDS)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat    (beat),
    .eop     (out_eop),
    .at_last (at_last)
  );

  assign cell_end = beat && at_last;
  assign out_src  = sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sel    <= SRC_NONE;
      prio_q <= 1'b0;
    end else begin
      if (!active || cell_end) prio_q <= cfg_ctrl_first;
      if (!active) begin
        active <= any;
        sel    <= win;
      end else if (cell_end) begin
        active <= 1'b0;
        sel    <= SRC_NONE;
      end
    end
  end

  // R9
  idle_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (out_src == SRC_NONE && !out_valid));
  // R5
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cell_end) |=> (active && $stable(out_src)));
  // R8
  prio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cell_end) |=> $stable(prio_q));
  // R1
  data_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(active) && !$past(prio_q) && $past(in_avail[0])) |-> out_src == SRC_DATA);
  // R2
  ctrl_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(active) && $past(prio_q) && $past(in_avail[1])) |-> out_src == SRC_CTRL);
  // R3
  loop_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(active) && out_src == SRC_LOOP) |-> !$past(in_avail[0]) && !$past(in_avail[1]));
endmodule

// File: tb/tb_cell_prio_mux.sv
module tb_cell_prio_mux;
  import cpm_pkg::*;
  localparam int WORDS = 14;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cfg, out_valid, out_ready, out_sop, out_eop;
  logic [2:0] in_avail, in_valid, in_ready, in_sop, in_eop;
  logic [2:0][31:0] in_data;
  logic [31:0] out_data;
  logic [1:0] out_src;

  int checks = 0, fails = 0, cyc = 0;
  int cnt[3] = '{0, 0, 0};
  int widx[3] = '{0, 0, 0};
  logic [2:0] add = 3'b000, vgate = 3'b111;
  int mon_idx = 0, mon_src = 0, nlog = 0;
  int log_src[64];

  cell_prio_mux dut (
    .clk(clk), .rst_n(rst_n), .cfg_ctrl_first(cfg),
    .in_avail(in_avail), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_src(out_src)
  );

  // source queue models: word tag = {source in [25:24], index in [15:0]}
  always_comb begin
    for (int k = 0; k < 3; k++) begin
      in_avail[k] = cnt[k] > 0;
      in_valid[k] = in_avail[k] && vgate[k];
      in_data[k]  = {6'd0, 2'(k), 8'h5A, 16'(widx[k])};
      in_sop[k]   = widx[k] == 0;
      in_eop[k]   = widx[k] == WORDS - 1;
    end
  end

  always @(posedge clk) begin
    for (int k = 0; k < 3; k++) begin
      automatic int d = 0;
      if (add[k]) d = d + 1;
      if (in_valid[k] && in_ready[k]) begin
        if (widx[k] == WORDS - 1) begin
          widx[k] <= 0;
          d = d - 1;
        end else widx[k] <= widx[k] + 1;
      end
      cnt[k] <= cnt[k] + d;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // output monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (!rst_n) mon_idx = 0;
    else begin
      if (!out_ready) chk(in_ready == 3'b000, "R7", "ready during stall", int'(in_ready), 0);
      if (out_src == 2'd3) chk(!out_valid, "R9", "valid while idle", int'(out_valid), 0);
      else if (!in_valid[out_src]) chk(!out_valid, "R7", "valid without source word", int'(out_valid), 0);
      if (out_valid && out_ready) begin
        if (mon_idx == 0) begin
          mon_src = int'(out_data[25:24]);
          chk(out_sop, "R6", "start marker on first word", int'(out_sop), 1);
        end
        chk(out_data[25:24] == out_src, "R9", "out_src vs word source", int'(out_src), int'(out_data[25:24]));
        chk(int'(out_data[25:24]) == mon_src, "R5", "foreign word inside cell", int'(out_data[25:24]), mon_src);
        chk(int'(out_data[15:0]) == mon_idx, "R6", "word index", int'(out_data[15:0]), mon_idx);
        chk(out_eop == (mon_idx == WORDS - 1), "R6", "end marker position", int'(out_eop), int'(mon_idx == WORDS - 1));
        if (mon_idx == WORDS - 1) begin
          if (nlog < 64) log_src[nlog] = mon_src;
          nlog++;
          mon_idx = 0;
        end else mon_idx++;
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 60000);
      summary();
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic add_cells(input logic [2:0] m);
    @(posedge clk) #1 add = m;
    @(posedge clk) #1 add = 3'b000;
  endtask

  task automatic wait_idle();
    tick(2);
    while (cnt[0] > 0 || cnt[1] > 0 || cnt[2] > 0 || out_src != 2'd3) tick(1);
    tick(1);
  endtask

  task automatic chk_order(input int base, input int n, input int e0, input int e1,
                           input int e2, input string req);
    int e[3];
    e = '{e0, e1, e2};
    chk(nlog - base == n, req, "cell count", nlog - base, n);
    for (int i = 0; i < n && i < 3; i++)
      chk(log_src[base + i] == e[i], req, $sformatf("source of cell %0d", i), log_src[base + i], e[i]);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    tick(3);
    @(negedge clk);
    chk(!out_valid && in_ready == 3'b000 && out_src == 2'd3, "R10", "outputs in reset",
        int'({out_valid, in_ready, out_src}), 3);
    @(posedge clk) #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready == 3'b000 && out_src == 2'd3, "R10", "outputs after reset",
        int'({out_valid, in_ready, out_src}), 3);
  endtask

  task automatic t_data_first();
    int b;
    cfg = 1'b0; tick(2); b = nlog;
    add_cells(3'b111);
    wait_idle();
    chk_order(b, 3, 0, 1, 2, "R1");
  endtask

  task automatic t_ctrl_first();
    int b;
    cfg = 1'b1; tick(2); b = nlog;
    add_cells(3'b111);
    wait_idle();
    chk_order(b, 3, 1, 0, 2, "R2");
  endtask

  task automatic t_loop_lowest();
    int b;
    cfg = 1'b0; tick(2); b = nlog;
    add_cells(3'b100);
    tick(3);
    add_cells(3'b011);
    wait_idle();
    chk_order(b, 3, 2, 0, 1, "R3");
  endtask

  task automatic t_no_preempt();
    int b;
    cfg = 1'b0; tick(2); b = nlog;
    add_cells(3'b010);
    tick(4);
    add_cells(3'b001);
    wait_idle();
    chk_order(b, 2, 1, 0, 0, "R5");
  endtask

  task automatic t_backpressure();
    int b;
    cfg = 1'b0; tick(2); b = nlog;
    add_cells(3'b011);
    for (int i = 0; i < 120; i++) begin
      out_ready = (i % 3) != 1;
      vgate[0]  = (i % 5) != 2;
      tick(1);
    end
    out_ready = 1'b1;
    vgate = 3'b111;
    wait_idle();
    chk_order(b, 2, 0, 1, 0, "R7");
  endtask

  task automatic t_prio_switch();
    int b;
    cfg = 1'b1; tick(2); b = nlog;
    add_cells(3'b010);
    add_cells(3'b010);
    tick(3);
    cfg = 1'b0;
    add_cells(3'b001);
    wait_idle();
    chk_order(b, 3, 1, 0, 1, "R8");
  endtask

  task automatic t_reset_default();
    int b;
    rst_n = 1'b0;
    cfg = 1'b1;
    tick(2);
    b = nlog;
    add_cells(3'b111);
    @(posedge clk) #1 rst_n = 1'b1;
    wait_idle();
    chk_order(b, 3, 0, 1, 2, "R4");
  endtask

  initial begin
    rst_n = 1'b0;
    cfg = 1'b0;
    out_ready = 1'b1;
    t_reset_state();
    t_data_first();
    t_ctrl_first();
    t_loop_lowest();
    t_no_preempt();
    t_backpressure();
    t_prio_switch();
    t_reset_default();
    summary();
    $finish;
  end
endmodule